// File: doc/BRIEF.md
# Interrupt Pin Noise Rejection Filter

This block cleans up an external interrupt pin before falling-edge detection. The raw pin is first brought into the system clock domain through a flop chain. A pulse-width qualifier then moves its output only after the synchronized level has held a new value for a programmable number of system clocks: 8 or 32. A falling edge of the qualified level raises an interrupt request for exactly one clock.

An 8-bit control register sets the filter's behaviour. It holds a width-select bit, a filter-enable bit and a two-bit reset-level field. The reset-level field is only stored here; it is passed out unchanged for a low-voltage reset circuit elsewhere in the chip.

Three mode inputs force the filter into bypass whatever the enable bit holds: low-frequency crystal, the second low-crystal mode, and sleep. In bypass the qualified level follows the synchronized pin directly.

Top module: `int_noise_filter`

## Requirements
- R1: After reset the control register reads 8'h0F: width-select (bit 3) = 1, filter-enable (bit 2) = 1, reset-level field (bits 1:0) = 2'b11. After reset `pin_qual` is 1 and `irq` is 0.
- R2: Bits 7:4 of the control register ignore writes and always read as 0. A write of 8'hFF reads back as 8'h0F.
- R3: A write stores bits 3:0, which read back on the next cycle. Bits 1:0 appear unchanged on `rst_level` from the cycle after the write.
- R4: With width-select = 1 and filtering active, a low level that lasts 31 clocks is rejected. A low level of 32 or more clocks is accepted. The request for a pin driven low just after rising edge E is seen after edge E+34.
- R5: With width-select = 0 and filtering active, a low level of 7 clocks is rejected. A low level of 8 or more clocks is accepted, and its request is seen after edge E+10.
- R6: With filter-enable (bit 2) = 0, any low pulse of one clock or more gives a request after edge E+3. This delay is two synchronizer flops plus the qualified-level register.
- R7: While `lxt_mode` is 1, the filter is bypassed even with filter-enable = 1. A one-clock low pulse gives a request after edge E+3.
- R8: While `lxt2_mode` or `sleep_mode` is 1, the filter is bypassed in the same way. A one-clock low pulse gives a request after edge E+3.
- R9: The width count restarts whenever the synchronized pin returns to the qualified level. With width-select = 1, a 20-clock low, then a 1-clock high, then a 20-clock low is rejected.
- R10: `irq` is high for exactly one clock, and only in the first cycle in which `pin_qual` is 0 after being 1. A rising edge never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| pin_in | input | 1 | Raw external interrupt pin |
| lxt_mode | input | 1 | Low-frequency crystal mode, forces bypass |
| lxt2_mode | input | 1 | Second low-crystal mode, forces bypass |
| sleep_mode | input | 1 | Sleep mode, forces bypass |
| pin_qual | output | 1 | Qualified pin level |
| irq | output | 1 | One-cycle falling-edge interrupt request |
| rst_level | output | 2 | Stored reset-level field |

## Verification
Each pulse the driver sends is timed from the rising edge E just before the pin falls. An accepted request is due after edge E+2+threshold when filtering is active, and after edge E+3 in bypass. The driver queues that exact cycle number. The monitor compares every `irq` it sees, on the falling clock edge, against the head of the queue, and counts any request that arrives with nothing queued as a failure. Register contents change one edge after the write strobe, so reads and the `rst_level` checks are taken on the following falling edge. After each rejected pulse the bench confirms that `pin_qual` is still high and that no request was ever queued.

// File: rtl/nrf_pkg.sv
package nrf_pkg;

    typedef struct packed {
        logic       width_sel;
        logic       filt_en;
        logic [1:0] lvl;
    } nrf_ctrl_t;

    localparam int CTRL_BITS = 4;
    localparam logic [CTRL_BITS-1:0] CTRL_RESET = 4'hF;

endpackage

// File: rtl/nrf_ctrl_reg.sv
module nrf_ctrl_reg
    import nrf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output nrf_ctrl_t         ctrl
);
    localparam int PAD_W = DATA_W - CTRL_BITS;

    nrf_ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr) begin
            ctrl_d = nrf_ctrl_t'(wdata[CTRL_BITS-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= nrf_ctrl_t'(CTRL_RESET);
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign rdata = {{PAD_W{1'b0}}, ctrl_q};
    assign ctrl  = ctrl_q;

    // R3: the stored field tracks the written bits one edge later
    p_field_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (ctrl.lvl == $past(wdata[1:0])));

    // R2: upper read bits stay zero after any write
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (rdata[DATA_W-1:CTRL_BITS] == '0));

endmodule

// File: rtl/nrf_sync.sv
module nrf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/nrf_qualifier.sv
module nrf_qualifier #(
    parameter int WIDE_THR   = 32,
    parameter int NARROW_THR = 8,
    parameter int CNT_W      = $clog2(WIDE_THR + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s_in,
    input  logic bypass,
    input  logic width_sel,
    output logic qual
);
    localparam logic [CNT_W-1:0] WIDE_LIM   = CNT_W'(WIDE_THR - 1);
    localparam logic [CNT_W-1:0] NARROW_LIM = CNT_W'(NARROW_THR - 1);

    typedef struct packed {
        logic             qual;
        logic [CNT_W-1:0] cnt;
    } qstate_t;

    qstate_t st_d, st_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim  = width_sel ? WIDE_LIM : NARROW_LIM;
        st_d = st_q;
        if (bypass) begin
            st_d.qual = s_in;
            st_d.cnt  = '0;
        end else if (s_in == st_q.qual) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= lim) begin
            st_d.qual = s_in;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.qual <= 1'b1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign qual = st_q.qual;

    // R4/R5: outside bypass the level moves only after the count reached its limit
    p_change_at_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bypass) && (qual != $past(qual))) |-> ($past(st_q.cnt) >= $past(lim)));

    // R6: in bypass the level copies the synchronized input
    p_bypass_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bypass) |-> (qual == $past(s_in)));

    // R9: the count never runs past the wide limit
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= WIDE_LIM);

endmodule

// File: rtl/nrf_edge_det.sv
module nrf_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign fall = prev_q & ~lvl;

    // R10: a request never lasts more than one cycle
    p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/int_noise_filter.sv
module int_noise_filter
    import nrf_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int WIDE_THR    = 32,
    parameter int NARROW_THR  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              pin_in,
    input  logic              lxt_mode,
    input  logic              lxt2_mode,
    input  logic              sleep_mode,
    output logic              pin_qual,
    output logic              irq,
    output logic [1:0]        rst_level
);
    nrf_ctrl_t ctrl;
    logic      pin_sync;
    logic      bypass;

    nrf_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ctrl  (ctrl)
    );

    nrf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    always_comb begin
        bypass = !ctrl.filt_en || lxt_mode || lxt2_mode || sleep_mode;
    end

    nrf_qualifier #(
        .WIDE_THR   (WIDE_THR),
        .NARROW_THR (NARROW_THR)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_in      (pin_sync),
        .bypass    (bypass),
        .width_sel (ctrl.width_sel),
        .qual      (pin_qual)
    );

    nrf_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (pin_qual),
        .fall  (irq)
    );

    assign rst_level = ctrl.lvl;

    // R10: a request marks the first low cycle of the qualified level
    p_irq_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!pin_qual && $past(pin_qual)));

    // R7: crystal mode forces the level to follow the synchronized pin
    p_lxt_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lxt_mode) |-> (pin_qual == $past(pin_sync)));

    // R8: second crystal mode and sleep force the same bypass
    p_lxt2_sleep_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lxt2_mode) || $past(sleep_mode)) |-> (pin_qual == $past(pin_sync)));

endmodule

// File: tb/int_noise_filter_test.sv
module int_noise_filter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       pin_in = 1'b1;
    logic       lxt_mode = 1'b0;
    logic       lxt2_mode = 1'b0;
    logic       sleep_mode = 1'b0;
    logic       pin_qual;
    logic       irq;
    logic [1:0] rst_level;

    typedef struct {
        int    cyc;
        string tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    int  cyc = 0;
    int  tests = 0;
    int  fails = 0;
    bit  done = 1'b0;

    int_noise_filter uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .pin_in     (pin_in),
        .lxt_mode   (lxt_mode),
        .lxt2_mode  (lxt2_mode),
        .sleep_mode (sleep_mode),
        .pin_qual   (pin_qual),
        .irq        (irq),
        .rst_level  (rst_level)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: every request is compared against the head of the queue
    always @(negedge clk) begin
        if (rst_n && irq && !done) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R10 spurious irq: actual cycle %0d, expected none", cyc);
            end else begin
                exp_item_t e;
                e = exp_q.pop_front();
                if (e.cyc != cyc) begin
                    fails++;
                    $display("FAIL %s irq cycle: actual %0d, expected %0d", e.tag, cyc, e.cyc);
                end
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h, expected %0h", tag, act, exp);
        end
    endtask

    task automatic write_reg(logic [7:0] v);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    // driver: low pulse of len clocks; lat = 0 means it must be rejected
    task automatic pulse_low(int len, int lat, string tag);
        int e;
        @(negedge clk);
        e = cyc;
        pin_in = 1'b0;
        if (lat > 0) exp_q.push_back('{cyc: e + lat, tag: tag});
        repeat (len) @(negedge clk);
        pin_in = 1'b1;
        if (lat == 0) check({tag, " rejected pulse keeps level high"}, int'(pin_qual), 1);
        repeat (60) @(negedge clk);
        check({tag, " queue drained"}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", reg_rdata, 8'h0F);
        check("R1 rst_level", rst_level, 2'b11);
        check("R1 pin_qual", pin_qual, 1);
        check("R1 irq", irq, 0);

        // R2 upper bits
        write_reg(8'hFF);
        check("R2 rdata", reg_rdata, 8'h0F);
        // R3 stored field
        write_reg(8'hAA);
        check("R3 rdata", reg_rdata, 8'h0A);
        check("R3 rst_level", rst_level, 2'b10);
        write_reg(8'h5D);
        check("R3 rdata", reg_rdata, 8'h0D);
        check("R3 rst_level", rst_level, 2'b01);
        write_reg(8'h0F);

        // R4 wide threshold
        pulse_low(31, 0, "R4");
        pulse_low(32, 34, "R4");
        pulse_low(45, 34, "R4");

        // R9 count restart
        @(negedge clk);
        pin_in = 1'b0;
        repeat (20) @(negedge clk);
        pin_in = 1'b1;
        @(negedge clk);
        pulse_low(20, 0, "R9");

        // R5 narrow threshold
        write_reg(8'h07);
        pulse_low(7, 0, "R5");
        pulse_low(8, 10, "R5");
        pulse_low(12, 10, "R5");

        // R6 enable off
        write_reg(8'h0B);
        pulse_low(1, 3, "R6");
        pulse_low(3, 3, "R6");

        // R7 crystal mode overrides enable
        write_reg(8'h0F);
        lxt_mode = 1'b1;
        pulse_low(1, 3, "R7");
        lxt_mode = 1'b0;
        repeat (5) @(negedge clk);

        // R8 second crystal mode and sleep
        lxt2_mode = 1'b1;
        pulse_low(1, 3, "R8");
        lxt2_mode = 1'b0;
        repeat (5) @(negedge clk);
        sleep_mode = 1'b1;
        pulse_low(1, 3, "R8");
        sleep_mode = 1'b0;
        repeat (5) @(negedge clk);

        // R10 no request on the rising edge; filter active again
        pulse_low(31, 0, "R10");
        check("R10 irq idle", irq, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule